// File: doc/BRIEF.md
# TLB Address-Array Write Engine

This block holds the tag side of a unified TLB and a small instruction TLB. Each entry stores a virtual page number, an address-space identifier, a dirty bit and a valid bit. It accepts 32-bit stores into a memory-mapped window that exposes the unified TLB's tag array. Each store either rewrites one entry chosen by its address, or searches both TLBs for a page/space key and updates what it finds.

The block also keeps the 6-bit replacement counter of the MMU control word. It tells the host which page must be dropped from any translation caches, and it raises a multiple-hit exception when the associative search finds the key twice. The associative search walks the unified TLB one entry per clock, with `busy` high. Stores offered while `busy` is high are not taken, so the host holds them until `busy` falls. A separate refill port loads the instruction TLB.

Top module: `utlb_aa_writer`

## Requirements
- R1: A store acts only when `wr_addr[26:24]` equals 3'b110. Stores with any other value in that field change no entry, leave `urc` unchanged and produce no flush or exception.
- R2: The store data splits into page number `wr_data[31:10]`, dirty `wr_data[9]`, valid `wr_data[8]` and space id `wr_data[7:0]`. `wr_addr[7]` = 0 selects indexed mode, with the entry number in `wr_addr[13:8]`. `wr_addr[7]` = 1 selects associative mode. Refill data uses the same field layout.
- R3: An indexed store rewrites all four fields of the chosen entry at the accepting clock edge, advances `urc` once at that edge, and never raises `busy`.
- R4: An indexed store that replaces a valid entry pulses `flush_vld` for one cycle after the accepting edge, with `flush_addr` = old page number << 10. It does not pulse when an instruction-TLB entry equal in all four fields to the old entry exists.
- R5: After reset `urc` is 0. Each advance takes `urc`+1, or 0 when `urc`+1 equals `urb` or equals 63. `urc` never reads 63.
- R6: An associative store raises `busy` at the accepting edge. It then visits unified entries 0 to 63 in order, one per clock. An entry with V clear is passed over and does not advance `urc`. Each valid entry visited advances `urc` once. A valid entry whose page number and space id both equal the key takes the key's V and D bits.
- R7: When a second valid entry matches during the walk, that entry is left unchanged and does not advance `urc`. `exc_vld` pulses for one cycle with `exc_code` = 12'h140 and `exc_addr` = the store address. The walk ends there.
- R8: One clock after the walk ends, the lowest-numbered instruction-TLB entry whose page number and space id equal the key is updated, whether or not it is valid. If a unified entry matched, that entry receives a full copy of the first matching unified entry. Otherwise only its V bit takes the key's V. `busy` falls at this edge.
- R9: At the edge where `busy` falls, `flush_vld` pulses with `flush_addr` = key page << 10 if any matched entry in either TLB went from valid to invalid.
- R10: Stores and refills offered while `busy` is high have no effect.
- R11: A refill while idle writes `itlb_fill_data` into instruction-TLB entry `itlb_fill_idx` at the clock edge.
- R12: After reset every entry reads as all zero (invalid), and `busy`, `flush_vld` and `exc_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store request into the mapped window |
| wr_addr | input | 32 | Store address (region, mode, entry number) |
| wr_data | input | 32 | Store data (page, dirty, valid, space id) |
| urb | input | 6 | Replacement boundary field of the MMU control word |
| itlb_fill_en | input | 1 | Instruction-TLB refill strobe |
| itlb_fill_idx | input | 2 | Refill entry number |
| itlb_fill_data | input | 32 | Refill entry contents, same layout as store data |
| busy | output | 1 | Associative walk in progress; stores are not taken |
| urc | output | 6 | Replacement counter field of the MMU control word |
| flush_vld | output | 1 | One-cycle page-flush request |
| flush_addr | output | 32 | Page base to flush |
| exc_vld | output | 1 | One-cycle multiple-hit exception |
| exc_code | output | 12 | Exception code (12'h140) |
| exc_addr | output | 32 | Store address that caused the exception |

## Verification
The bench probes the invalid-entry skip in the walk. A design that advanced the counter on every slot would drift `urc` ahead of the model within the first scan. It builds a duplicated key so the walk must stop at the second hit. A design that carried on, or that applied the duplicate's update, shows the exception at the wrong cycle or a late `busy` fall. The instruction-TLB copy and the identical-entry flush exemption are checked together: a missed copy turns a later silent overwrite into a flush. The counter is also driven into both wrap points, the boundary field and 63, and stores are injected in the middle of a walk, where an engine that accepted them leaves an entry valid that must stay empty.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

   // field widths fixed by the 32-bit store word layout
   localparam int unsigned VPN_W   = 22;
   localparam int unsigned ASID_W  = 8;
   localparam int unsigned PAGE_SH = 10;

   localparam int unsigned RGN_LSB  = 24;
   localparam int unsigned MODE_BIT = 7;
   localparam int unsigned IDX_LSB  = 8;

   localparam logic [2:0]  RGN_UTLB_TAG  = 3'b110;
   localparam logic [11:0] EXC_MULTI_HIT = 12'h140;

   typedef struct packed {
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic              d;
      logic              v;
   } tlb_ent_t;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_SCAN = 2'd1,
      S_ITLB = 2'd2
   } walk_st_e;

   function automatic tlb_ent_t word_to_ent(input logic [31:0] w);
      tlb_ent_t e;
      e.vpn  = w[31:PAGE_SH];
      e.d    = w[9];
      e.v    = w[8];
      e.asid = w[ASID_W-1:0];
      return e;
   endfunction

   function automatic logic [31:0] page_base(input logic [VPN_W-1:0] vpn);
      return {vpn, {PAGE_SH{1'b0}}};
   endfunction

endpackage

// File: rtl/utlb_aa_decode.sv
module utlb_aa_decode
   import utlb_pkg::*;
#(
   parameter int unsigned IDX_W = 6
) (
   input  logic [31:0]      addr,
   input  logic [31:0]      data,
   output logic             rgn_hit,
   output logic             assoc,
   output logic [IDX_W-1:0] idx,
   output tlb_ent_t         ent
);

   generate
      if (IDX_LSB + IDX_W > RGN_LSB) begin : g_bad_idx
         $error("entry number field overlaps region field");
      end
   endgenerate

   always_comb begin
      rgn_hit = (addr[RGN_LSB +: 3] == RGN_UTLB_TAG);
      assoc   = addr[MODE_BIT];
      idx     = addr[IDX_LSB +: IDX_W];
      ent     = word_to_ent(data);
   end

endmodule

// File: rtl/utlb_urc_ctr.sv
module utlb_urc_ctr #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic [W-1:0] urb,
   output logic [W-1:0] urc
);

   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] urc_q;
   logic [W-1:0] nxt;

   assign nxt = urc_q + 1'b1;
   assign urc = urc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         urc_q <= '0;
      end else if (step) begin
         urc_q <= (nxt == urb || nxt == TOP) ? '0 : nxt;
      end
   end

   p_urc_below_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      urc_q != TOP);

   p_urc_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(urc_q) |-> (urc_q == '0 || urc_q == W'($past(urc_q) + 1'b1)));

   p_urc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(urc_q));

endmodule

// File: rtl/utlb_itlb_bank.sv
module utlb_itlb_bank
   import utlb_pkg::*;
#(
   parameter  int unsigned DEPTH = 4,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  tlb_ent_t          fill_ent,
   input  logic              upd_en,
   input  logic              upd_copy,
   input  tlb_ent_t          upd_src,
   input  logic [VPN_W-1:0]  key_vpn,
   input  logic [ASID_W-1:0] key_asid,
   input  logic              key_v,
   input  tlb_ent_t          probe,
   output logic              probe_same,
   output logic              hit,
   output logic              hit_valid
);

   generate
      if (DEPTH < 2 || DEPTH != (1 << IDX_W)) begin : g_bad_depth
         $error("instruction TLB depth must be a power of two of at least 2");
      end
   endgenerate

   tlb_ent_t         ent_q [DEPTH];
   logic [DEPTH-1:0] key_eq;
   logic [DEPTH-1:0] same_eq;
   logic [IDX_W-1:0] hit_idx;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
         assign key_eq[g]  = (ent_q[g].vpn == key_vpn) && (ent_q[g].asid == key_asid);
         assign same_eq[g] = (ent_q[g] == probe);
      end
   endgenerate

   // lowest index wins
   always_comb begin
      hit_idx = '0;
      for (int j = DEPTH - 1; j >= 0; j--) begin
         if (key_eq[j]) hit_idx = IDX_W'(j);
      end
      hit        = |key_eq;
      hit_valid  = ent_q[hit_idx].v;
      probe_same = |same_eq;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else if (upd_en) begin
         if (hit) begin
            if (upd_copy) ent_q[hit_idx]   <= upd_src;
            else          ent_q[hit_idx].v <= key_v;
         end
      end else if (fill_en) begin
         ent_q[fill_idx] <= fill_ent;
      end
   end

   p_no_fill_in_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |-> !fill_en);

endmodule

// File: rtl/utlb_aa_writer.sv
module utlb_aa_writer
   import utlb_pkg::*;
#(
   parameter  int unsigned UTLB_DEPTH = 64,
   parameter  int unsigned ITLB_DEPTH = 4,
   localparam int unsigned UIDX_W     = $clog2(UTLB_DEPTH),
   localparam int unsigned IIDX_W     = $clog2(ITLB_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [UIDX_W-1:0] urb,
   input  logic              itlb_fill_en,
   input  logic [IIDX_W-1:0] itlb_fill_idx,
   input  logic [31:0]       itlb_fill_data,
   output logic              busy,
   output logic [UIDX_W-1:0] urc,
   output logic              flush_vld,
   output logic [31:0]       flush_addr,
   output logic              exc_vld,
   output logic [11:0]       exc_code,
   output logic [31:0]       exc_addr
);

   localparam logic [UIDX_W-1:0] LAST = UIDX_W'(UTLB_DEPTH - 1);

   generate
      if (UTLB_DEPTH < 2 || UTLB_DEPTH != (1 << UIDX_W)) begin : g_bad_udepth
         $error("unified TLB depth must be a power of two of at least 2");
      end
   endgenerate

   // decode
   logic              dec_rgn;
   logic              dec_assoc;
   logic [UIDX_W-1:0] dec_idx;
   tlb_ent_t          dec_ent;

   utlb_aa_decode #(.IDX_W(UIDX_W)) u_dec (
      .addr    (wr_addr),
      .data    (wr_data),
      .rgn_hit (dec_rgn),
      .assoc   (dec_assoc),
      .idx     (dec_idx),
      .ent     (dec_ent)
   );

   // walk state
   walk_st_e          st_q;
   logic [UIDX_W-1:0] ptr_q;
   logic [UIDX_W-1:0] hidx_q;
   logic              hit_q;
   logic              nf_q;
   tlb_ent_t          key_q;
   logic [31:0]       kaddr_q;
   tlb_ent_t          utlb_q [UTLB_DEPTH];

   logic     accept;
   tlb_ent_t cur;
   tlb_ent_t old_ent;
   logic     cur_match;
   logic     multi;
   logic     urc_step;

   assign busy      = (st_q != S_IDLE);
   assign accept    = wr_en && dec_rgn && (st_q == S_IDLE);
   assign cur       = utlb_q[ptr_q];
   assign old_ent   = utlb_q[dec_idx];
   assign cur_match = cur.v && (cur.vpn == key_q.vpn) && (cur.asid == key_q.asid);
   assign multi     = (st_q == S_SCAN) && cur_match && hit_q;
   assign urc_step  = (accept && !dec_assoc) ||
                      ((st_q == S_SCAN) && cur.v && !multi);

   // instruction TLB
   logic i_probe_same;
   logic i_hit;
   logic i_hit_valid;

   utlb_itlb_bank #(.DEPTH(ITLB_DEPTH)) u_itlb (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_en    (itlb_fill_en && (st_q == S_IDLE)),
      .fill_idx   (itlb_fill_idx),
      .fill_ent   (word_to_ent(itlb_fill_data)),
      .upd_en     (st_q == S_ITLB),
      .upd_copy   (hit_q),
      .upd_src    (utlb_q[hidx_q]),
      .key_vpn    (key_q.vpn),
      .key_asid   (key_q.asid),
      .key_v      (key_q.v),
      .probe      (old_ent),
      .probe_same (i_probe_same),
      .hit        (i_hit),
      .hit_valid  (i_hit_valid)
   );

   utlb_urc_ctr #(.W(UIDX_W)) u_urc (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (urc_step),
      .urb   (urb),
      .urc   (urc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         ptr_q      <= '0;
         hidx_q     <= '0;
         hit_q      <= 1'b0;
         nf_q       <= 1'b0;
         key_q      <= '0;
         kaddr_q    <= '0;
         flush_vld  <= 1'b0;
         flush_addr <= '0;
         exc_vld    <= 1'b0;
         exc_code   <= '0;
         exc_addr   <= '0;
         for (int i = 0; i < UTLB_DEPTH; i++) utlb_q[i] <= '0;
      end else begin
         flush_vld <= 1'b0;
         exc_vld   <= 1'b0;
         unique case (st_q)
            S_IDLE: begin
               if (accept) begin
                  if (dec_assoc) begin
                     st_q    <= S_SCAN;
                     ptr_q   <= '0;
                     hit_q   <= 1'b0;
                     nf_q    <= 1'b0;
                     key_q   <= dec_ent;
                     kaddr_q <= wr_addr;
                  end else begin
                     utlb_q[dec_idx] <= dec_ent;
                     if (old_ent.v && !i_probe_same) begin
                        flush_vld  <= 1'b1;
                        flush_addr <= page_base(old_ent.vpn);
                     end
                  end
               end
            end
            S_SCAN: begin
               if (multi) begin
                  exc_vld  <= 1'b1;
                  exc_code <= EXC_MULTI_HIT;
                  exc_addr <= kaddr_q;
                  st_q     <= S_ITLB;
               end else begin
                  if (cur_match) begin
                     utlb_q[ptr_q].v <= key_q.v;
                     utlb_q[ptr_q].d <= key_q.d;
                     hit_q           <= 1'b1;
                     hidx_q          <= ptr_q;
                     if (!key_q.v) nf_q <= 1'b1;
                  end
                  if (ptr_q == LAST) st_q  <= S_ITLB;
                  else               ptr_q <= ptr_q + 1'b1;
               end
            end
            S_ITLB: begin
               st_q <= S_IDLE;
               if (nf_q || (i_hit && i_hit_valid && !key_q.v)) begin
                  flush_vld  <= 1'b1;
                  flush_addr <= page_base(key_q.vpn);
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   p_foreign_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !dec_rgn && !busy) |=> (!busy && !flush_vld && $stable(urc)));

   p_indexed_no_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dec_rgn && !dec_assoc && !busy) |=> !busy);

   p_assoc_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && dec_rgn && dec_assoc && !busy) |=> busy);

   p_exc_inside_walk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_vld |-> (busy && $past(busy)));

   p_exc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_vld |=> !exc_vld);

endmodule

// File: tb/sim_utlb_aa_writer.sv
module sim_utlb_aa_writer;
   import utlb_pkg::*;

   localparam int UD = 64;
   localparam int ID = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [31:0] wr_addr;
   logic [31:0] wr_data;
   logic [5:0]  urb;
   logic        itlb_fill_en;
   logic [1:0]  itlb_fill_idx;
   logic [31:0] itlb_fill_data;
   logic        busy;
   logic [5:0]  urc;
   logic        flush_vld;
   logic [31:0] flush_addr;
   logic        exc_vld;
   logic [11:0] exc_code;
   logic [31:0] exc_addr;

   always #4 clk = ~clk;

   utlb_aa_writer #(.UTLB_DEPTH(UD), .ITLB_DEPTH(ID)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .urb(urb), .itlb_fill_en(itlb_fill_en), .itlb_fill_idx(itlb_fill_idx),
      .itlb_fill_data(itlb_fill_data), .busy(busy), .urc(urc), .flush_vld(flush_vld),
      .flush_addr(flush_addr), .exc_vld(exc_vld), .exc_code(exc_code), .exc_addr(exc_addr)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // behavioural model
   logic [21:0] mu_vpn [UD];
   logic [7:0]  mu_asid[UD];
   bit          mu_d   [UD];
   bit          mu_v   [UD];
   logic [21:0] mi_vpn [ID];
   logic [7:0]  mi_asid[ID];
   bit          mi_d   [ID];
   bit          mi_v   [ID];
   int          m_urc;
   int          m_urb;

   localparam logic [31:0] TAG_BASE = 32'hF600_0000;

   function automatic int urc_next(input int u);
      int n;
      n = u + 1;
      if (n == m_urb || n == UD - 1) return 0;
      return n;
   endfunction

   function automatic bit itlb_has_copy(input int k);
      for (int j = 0; j < ID; j++)
         if (mi_vpn[j] == mu_vpn[k] && mi_asid[j] == mu_asid[k] &&
             mi_d[j] == mu_d[k] && mi_v[j] == mu_v[k]) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic quiet(input string req);
      chk({req, " busy"}, 32'(busy), 32'd0);
      chk({req, " flush"}, 32'(flush_vld), 32'd0);
      chk({req, " exc"}, 32'(exc_vld), 32'd0);
      chk({req, " urc"}, 32'(urc), 32'(m_urc));
   endtask

   task automatic idx_write(input int idx, input logic [21:0] vpn, input logic [7:0] asid,
                            input bit d, input bit v, input string req);
      bit          exp_f;
      logic [31:0] exp_fa;
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = TAG_BASE | 32'(idx << 8);
      wr_data = {vpn, d, v, asid};
      @(negedge clk);
      wr_en  = 1'b0;
      exp_f  = mu_v[idx] && !itlb_has_copy(idx);
      exp_fa = {mu_vpn[idx], 10'b0};
      mu_vpn[idx] = vpn; mu_asid[idx] = asid; mu_d[idx] = d; mu_v[idx] = v;
      m_urc = urc_next(m_urc);
      chk({req, " busy"}, 32'(busy), 32'd0);
      chk({req, " urc"}, 32'(urc), 32'(m_urc));
      chk({req, " flush"}, 32'(flush_vld), 32'(exp_f));
      if (exp_f) chk({req, " flush_addr"}, flush_addr, exp_fa);
   endtask

   task automatic raw_write(input logic [31:0] a, input logic [31:0] dt, input string req);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = dt;
      @(negedge clk);
      wr_en = 1'b0;
      quiet(req);
   endtask

   task automatic fill(input int idx, input logic [21:0] vpn, input logic [7:0] asid,
                       input bit d, input bit v);
      @(negedge clk);
      itlb_fill_en = 1'b1; itlb_fill_idx = 2'(idx); itlb_fill_data = {vpn, d, v, asid};
      @(negedge clk);
      itlb_fill_en = 1'b0;
      mi_vpn[idx] = vpn; mi_asid[idx] = asid; mi_d[idx] = d; mi_v[idx] = v;
      quiet("R11 fill");
   endtask

   task automatic assoc_write(input logic [21:0] vpn, input logic [7:0] asid,
                              input bit d, input bit v, input bit inject, input string req);
      int hit;
      bit nf;
      bit exc;
      bit vb;
      int jm;
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = TAG_BASE | 32'h80;
      wr_data = {vpn, d, v, asid};
      @(negedge clk);
      wr_en = 1'b0;
      chk({req, " R6 busy rise"}, 32'(busy), 32'd1);
      chk({req, " urc at start"}, 32'(urc), 32'(m_urc));
      hit = -1;
      nf  = 1'b0;
      for (int i = 0; i < UD; i++) begin
         exc = 1'b0;
         if (inject && i == 2) begin
            // R10: offered while busy, must be dropped
            wr_en = 1'b1; wr_addr = TAG_BASE | 32'(30 << 8); wr_data = {22'h2AAAA, 1'b0, 1'b1, 8'h33};
            itlb_fill_en = 1'b1; itlb_fill_idx = 2'd0; itlb_fill_data = {22'h2BBBB, 1'b0, 1'b1, 8'h44};
         end
         @(negedge clk);
         wr_en = 1'b0;
         itlb_fill_en = 1'b0;
         vb = mu_v[i];
         if (vb && mu_vpn[i] == vpn && mu_asid[i] == asid) begin
            if (hit >= 0) exc = 1'b1;
            else begin
               if (!v) nf = 1'b1;
               mu_v[i] = v; mu_d[i] = d; hit = i;
            end
         end
         if (vb && !exc) m_urc = urc_next(m_urc);
         chk({req, " R6 busy"}, 32'(busy), 32'd1);
         chk({req, " R6 urc"}, 32'(urc), 32'(m_urc));
         chk({req, " R7 exc"}, 32'(exc_vld), 32'(exc));
         chk({req, " flush during walk"}, 32'(flush_vld), 32'd0);
         if (exc) begin
            chk({req, " R7 exc_code"}, 32'(exc_code), 32'h140);
            chk({req, " R7 exc_addr"}, exc_addr, TAG_BASE | 32'h80);
            break;
         end
      end
      @(negedge clk);
      jm = -1;
      for (int j = ID - 1; j >= 0; j--)
         if (mi_vpn[j] == vpn && mi_asid[j] == asid) jm = j;
      if (jm >= 0) begin
         if (mi_v[jm] && !v) nf = 1'b1;
         if (hit >= 0) begin
            mi_vpn[jm] = mu_vpn[hit]; mi_asid[jm] = mu_asid[hit];
            mi_d[jm] = mu_d[hit]; mi_v[jm] = mu_v[hit];
         end else mi_v[jm] = v;
      end
      chk({req, " R8 busy fall"}, 32'(busy), 32'd0);
      chk({req, " R9 flush"}, 32'(flush_vld), 32'(nf));
      if (nf) chk({req, " R9 flush_addr"}, flush_addr, {vpn, 10'b0});
      chk({req, " urc end"}, 32'(urc), 32'(m_urc));
      chk({req, " exc end"}, 32'(exc_vld), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; urb = '0;
      itlb_fill_en = 1'b0; itlb_fill_idx = '0; itlb_fill_data = '0;
      m_urc = 0; m_urb = 0;
      for (int i = 0; i < UD; i++) begin
         mu_vpn[i] = '0; mu_asid[i] = '0; mu_d[i] = 1'b0; mu_v[i] = 1'b0;
      end
      for (int j = 0; j < ID; j++) begin
         mi_vpn[j] = '0; mi_asid[j] = '0; mi_d[j] = 1'b0; mi_v[j] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      quiet("R12 reset");

      // R3 indexed write into an empty slot
      idx_write(5, 22'h12345, 8'h01, 1'b0, 1'b1, "R3 fresh");
      // R4 overwrite of a valid slot flushes the old page
      idx_write(5, 22'h0ABCD, 8'h02, 1'b1, 1'b1, "R4 replace");
      // R11 refill an identical copy, R4 exemption
      fill(2, 22'h0ABCD, 8'h02, 1'b1, 1'b1);
      idx_write(5, 22'h1F00F, 8'h03, 1'b0, 1'b1, "R4 exempt");
      // R1 other regions are ignored
      raw_write(32'hF700_0500, {22'h00001, 2'b11, 8'h09}, "R1 data region");
      raw_write(32'hF000_0580, {22'h00002, 2'b11, 8'h09}, "R1 icache region");
      idx_write(5, 22'h1F00F, 8'h03, 1'b0, 1'b1, "R1 entry untouched");

      // R6/R9 associative invalidate of one entry
      assoc_write(22'h1F00F, 8'h03, 1'b1, 1'b0, 1'b0, "R9 single");

      // R7/R8 duplicate key, copy into the instruction TLB
      idx_write(10, 22'h00D0D, 8'h07, 1'b0, 1'b1, "R2 dup a");
      idx_write(20, 22'h00D0D, 8'h07, 1'b0, 1'b1, "R2 dup b");
      fill(1, 22'h00D0D, 8'h07, 1'b0, 1'b0);
      assoc_write(22'h00D0D, 8'h07, 1'b1, 1'b1, 1'b0, "R7 multi");
      // R8 the copy makes this overwrite silent
      idx_write(10, 22'h0EEEE, 8'h07, 1'b0, 1'b1, "R8 copy seen");

      // R8 V-only update with no unified match, R9 flush from instruction side
      fill(3, 22'h0F0F0, 8'h09, 1'b0, 1'b1);
      assoc_write(22'h0F0F0, 8'h09, 1'b0, 1'b0, 1'b0, "R8 vonly");
      idx_write(11, 22'h0F0F0, 8'h09, 1'b0, 1'b1, "R8 vonly follow");
      idx_write(11, 22'h01111, 8'h01, 1'b0, 1'b1, "R8 vonly check");

      // R10 stores and refills during a walk are dropped
      assoc_write(22'h05555, 8'h01, 1'b0, 1'b1, 1'b1, "R10 walk");
      idx_write(30, 22'h01234, 8'h05, 1'b0, 1'b1, "R10 slot empty");
      idx_write(0, 22'h2BBBB, 8'h44, 1'b0, 1'b1, "R10 itlb fill dropped");
      idx_write(0, 22'h00001, 8'h01, 1'b0, 1'b1, "R10 itlb check");

      // R5 wrap at the boundary field
      @(negedge clk);
      urb = 6'd4; m_urb = 4;
      for (int k = 0; k < 8; k++) idx_write(40, 22'(k), 8'h10, 1'b0, 1'b0, "R5 wrap urb");
      // R5 wrap at 63
      @(negedge clk);
      urb = 6'd0; m_urb = 0;
      for (int k = 0; k < 66; k++) idx_write(41, 22'(k), 8'h11, 1'b0, 1'b0, "R5 wrap top");

      // R6 walk with many valid entries moves urc per valid slot
      assoc_write(22'h3FFFF, 8'hFF, 1'b0, 1'b1, 1'b0, "R6 no match");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule